// File: doc/BRIEF.md
# Frame Event Interrupt Controller

This block gathers single-cycle event pulses from a frame-processing engine, such as the end of a processed frame or dark-frame data that arrived from memory too late, and holds each one in a sticky status bit. Every event carries its own enable bit and its own destination bit that steers it to one of two level-sensitive interrupt lines, one for the host processor and one for the signal processor.

Software reaches three registers through a small synchronous bus. The status register is write-one-to-clear and is never altered by a read. The enable register and the route register are plain read/write registers. A status bit records its event whether or not the event is enabled, so software can poll masked events. Reads are registered: the data requested with a read strobe appears on the read bus one cycle later.

Register offsets: 0 is status, 1 is enable, 2 is route, and 3 is unused. Event bit 0 is end-of-frame and event bit 1 is late dark-frame data. The remaining bits are further engine events.

Top module: `fevt_irq_ctrl`

## Requirements
- R1: After reset, the status, enable and route registers are all zero, both interrupt lines are low and the read bus is zero.
- R2: A pulse on event input i sets status bit i at the next clock edge, whatever the value of enable bit i. Bit 0 is end-of-frame and bit 1 is late dark-frame data.
- R3: A read strobe at offset 0 puts the status value on the read bus one cycle later and clears no status bit, even when repeated.
- R4: Writing to offset 0 clears each status bit whose write-data bit is 1. A status bit whose write-data bit is 0 is left unchanged.
- R5: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: When the enable bit of an event is 0, that event's status bit has no effect on either interrupt line.
- R7: Route bit i selects the destination of event i: 0 sends it to `irq_host` and 1 sends it to `irq_dsp`. Each line is high exactly while some event routed to it has both its status bit and its enable bit set.
- R8: Writing a 1 to enable bit i (offset 1) while status bit i is already set raises the routed line in the cycle after the write.
- R9: The enable register (offset 1) and the route register (offset 2) read back the last value written. Bits above the event count read as zero, and offset 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | NUM_EVT | One-cycle event pulses from the engine |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_host | output | 1 | Level interrupt to the host processor |
| irq_dsp | output | 1 | Level interrupt to the signal processor |

## Verification
Two functions can act on the same status bit in one cycle: an incoming event pulse and a write-one-to-clear from software. The bench provokes this by driving the pulse and the status write in the same clock. It then judges the result through a status read and through the interrupt line the event is routed to, and both must show the bit still set. A second overlap is a configuration write that changes the enable or route of a bit that is already pending. Here the bench checks that the interrupt lines change in the cycle that follows that write.

// File: rtl/fevt_pkg.sv
package fevt_pkg;

    localparam int FEVT_ADDR_W = 2;

    typedef enum logic [FEVT_ADDR_W-1:0] {
        OFS_STATUS = 2'd0,
        OFS_ENABLE = 2'd1,
        OFS_ROUTE  = 2'd2,
        OFS_SPARE  = 2'd3
    } fevt_ofs_e;

endpackage

// File: rtl/fevt_status_bank.sv
module fevt_status_bank #(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic [NUM_EVT-1:0] clr_mask,
    output logic [NUM_EVT-1:0] status_q
);

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[g] <= 1'b0;
            end else if (evt_set[g]) begin
                status_q[g] <= 1'b1;
            end else if (clr_mask[g]) begin
                status_q[g] <= 1'b0;
            end
        end

        AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            evt_set[g] |=> status_q[g]); // R5

        AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[g] && !clr_mask[g]) |=> status_q[g]); // R4

        AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!status_q[g] && !evt_set[g]) |=> !status_q[g]); // R2
    end

endmodule

// File: rtl/fevt_cfg_regs.sv
module fevt_cfg_regs #(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_enable,
    input  logic               wr_route,
    input  logic [NUM_EVT-1:0] wr_bits,
    output logic [NUM_EVT-1:0] enable_q,
    output logic [NUM_EVT-1:0] route_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_enable) begin
            enable_q <= wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= '0;
        end else if (wr_route) begin
            route_q <= wr_bits;
        end
    end

    AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> (enable_q == $past(wr_bits))); // R9

    AST_ROUTE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_route |=> (route_q == $past(wr_bits))); // R9

endmodule

// File: rtl/fevt_irq_route.sv
module fevt_irq_route #(
    parameter int NUM_EVT = 4
) (
    input  logic [NUM_EVT-1:0] status,
    input  logic [NUM_EVT-1:0] enable,
    input  logic [NUM_EVT-1:0] route,
    output logic               irq_host,
    output logic               irq_dsp
);

    logic [NUM_EVT-1:0] live;

    always_comb begin
        live     = status & enable;
        irq_host = |(live & ~route);
        irq_dsp  = |(live & route);
    end

endmodule

// File: rtl/fevt_irq_ctrl.sv
module fevt_irq_ctrl
    import fevt_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int DATA_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_EVT-1:0]     evt_pulse,
    input  logic                   bus_we,
    input  logic                   bus_re,
    input  logic [FEVT_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   irq_host,
    output logic                   irq_dsp
);

    logic [NUM_EVT-1:0] status_q;
    logic [NUM_EVT-1:0] enable_q;
    logic [NUM_EVT-1:0] route_q;
    logic [NUM_EVT-1:0] wr_bits;
    logic [NUM_EVT-1:0] clr_mask;
    logic               wr_enable;
    logic               wr_route;
    logic [DATA_W-1:0]  rd_mux;
    fevt_ofs_e          ofs;

    assign wr_bits = bus_wdata[NUM_EVT-1:0];

    if (DATA_W > NUM_EVT) begin : g_spare_bits
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_EVT];
    end

    always_comb begin
        ofs       = fevt_ofs_e'(bus_addr);
        clr_mask  = '0;
        wr_enable = 1'b0;
        wr_route  = 1'b0;
        if (bus_we) begin
            unique case (ofs)
                OFS_STATUS: clr_mask  = wr_bits;
                OFS_ENABLE: wr_enable = 1'b1;
                OFS_ROUTE:  wr_route  = 1'b1;
                OFS_SPARE:  ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (ofs)
            OFS_STATUS: rd_mux[NUM_EVT-1:0] = status_q;
            OFS_ENABLE: rd_mux[NUM_EVT-1:0] = enable_q;
            OFS_ROUTE:  rd_mux[NUM_EVT-1:0] = route_q;
            OFS_SPARE:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_mux;
        end
    end

    fevt_status_bank #(.NUM_EVT(NUM_EVT)) status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_pulse),
        .clr_mask (clr_mask),
        .status_q (status_q)
    );

    fevt_cfg_regs #(.NUM_EVT(NUM_EVT)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_enable (wr_enable),
        .wr_route  (wr_route),
        .wr_bits   (wr_bits),
        .enable_q  (enable_q),
        .route_q   (route_q)
    );

    fevt_irq_route #(.NUM_EVT(NUM_EVT)) route_i (
        .status   (status_q),
        .enable   (enable_q),
        .route    (route_q),
        .irq_host (irq_host),
        .irq_dsp  (irq_dsp)
    );

    initial begin
        AST_EVT_FITS_WORD: assert (NUM_EVT <= DATA_W); // R9
    end

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_host || irq_dsp) |-> (status_q != '0)); // R7

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> (!irq_host && !irq_dsp)); // R6

    AST_ENABLE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && ((wr_bits & status_q & ~route_q) != '0)) |=> irq_host); // R8

endmodule

// File: tb/fevt_irq_ctrl_tb_top.sv
module fevt_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_EVT    = 4;
    localparam int DATA_W     = 32;
    localparam int NVEC       = 14;

    // vector: we, addr[1:0], wdata[3:0], evt[3:0], exp_status[3:0], exp_host, exp_dsp
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 4'b0000, 4'b0001, 4'b0001, 1'b0, 1'b0}, // R2 end-of-frame, masked R6
        {1'b0, 2'd0, 4'b0000, 4'b0010, 4'b0011, 1'b0, 1'b0}, // R2 late dark data
        {1'b1, 2'd1, 4'b0001, 4'b0000, 4'b0011, 1'b1, 1'b0}, // R8 enable pending bit
        {1'b1, 2'd2, 4'b0001, 4'b0000, 4'b0011, 1'b0, 1'b1}, // R7 route bit0 to dsp
        {1'b1, 2'd1, 4'b0011, 4'b0000, 4'b0011, 1'b1, 1'b1}, // R7 R8 both lines
        {1'b1, 2'd0, 4'b0000, 4'b0000, 4'b0011, 1'b1, 1'b1}, // R4 zero write keeps
        {1'b1, 2'd0, 4'b0001, 4'b0000, 4'b0010, 1'b1, 1'b0}, // R4 clear bit0
        {1'b1, 2'd0, 4'b0010, 4'b0010, 4'b0010, 1'b1, 1'b0}, // R5 set beats clear
        {1'b1, 2'd0, 4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R4 clear bit1
        {1'b0, 2'd0, 4'b0000, 4'b0100, 4'b0100, 1'b0, 1'b0}, // R6 masked event
        {1'b1, 2'd1, 4'b1111, 4'b0000, 4'b0100, 1'b1, 1'b0}, // R8 enable all
        {1'b1, 2'd2, 4'b0100, 4'b0000, 4'b0100, 1'b0, 1'b1}, // R7 reroute bit2
        {1'b0, 2'd0, 4'b0000, 4'b1000, 4'b1100, 1'b1, 1'b1}, // R2 R7 bit3 to host
        {1'b1, 2'd0, 4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b0}  // R4 clear all
    };

    logic              clk;
    logic              rst_n;
    logic [NUM_EVT-1:0] evt_pulse;
    logic              bus_we;
    logic              bus_re;
    logic [1:0]        bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_host;
    logic              irq_dsp;

    int n_checks;
    int n_fails;
    int cycles;

    fevt_irq_ctrl #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_host  (irq_host),
        .irq_dsp   (irq_dsp)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [DATA_W-1:0] got,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_pulse = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = 2'd0;
        bus_wdata = '0;
    endtask

    // one bus/event cycle: drive at negedge, return at next negedge
    task automatic drive(input logic we, input logic [1:0] addr,
                         input logic [DATA_W-1:0] wdata, input logic [NUM_EVT-1:0] evt);
        bus_we    = we;
        bus_addr  = addr;
        bus_wdata = wdata;
        evt_pulse = evt;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic read_reg(input logic [1:0] addr, output logic [DATA_W-1:0] val);
        bus_re   = 1'b1;
        bus_addr = addr;
        @(negedge clk);
        idle_inputs();
        val = bus_rdata;
    endtask

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        logic [DATA_W-1:0] rd;
        n_checks = 0;
        n_fails  = 0;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 irq_host", {31'd0, irq_host}, '0);
        check("R1 irq_dsp", {31'd0, irq_dsp}, '0);
        check("R1 rdata", bus_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(2'd0, rd); check("R1 status", rd, '0);
        read_reg(2'd1, rd); check("R1 enable", rd, '0);
        read_reg(2'd2, rd); check("R1 route", rd, '0);

        // vector table: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            logic [16:0] v;
            v = VEC[i];
            drive(v[16], v[15:14], {28'd0, v[13:10]}, v[9:6]);
            check($sformatf("vec%0d R6 R7 R8 irq_host", i), {31'd0, irq_host}, {31'd0, v[1]});
            check($sformatf("vec%0d R6 R7 R8 irq_dsp", i), {31'd0, irq_dsp}, {31'd0, v[0]});
            read_reg(2'd0, rd);
            check($sformatf("vec%0d R2 R4 R5 status", i), rd, {28'd0, v[5:2]});
        end

        // R9 readback, upper bits zero, spare offset zero
        drive(1'b1, 2'd1, 32'hFFFF_FFF5, '0);
        read_reg(2'd1, rd); check("R9 enable readback", rd, 32'h0000_0005);
        read_reg(2'd2, rd); check("R9 route readback", rd, 32'h0000_0004);
        read_reg(2'd3, rd); check("R9 spare offset", rd, '0);

        // R3 repeated reads never clear
        drive(1'b0, 2'd0, '0, 4'b0001);
        read_reg(2'd0, rd); check("R3 first read", rd, 32'h1);
        read_reg(2'd0, rd); check("R3 second read", rd, 32'h1);
        check("R3 host still high", {31'd0, irq_host}, 32'h1);
        // R3 read data arrives one cycle after the strobe only
        bus_re = 1'b0; bus_addr = 2'd1;
        @(negedge clk);
        check("R3 no strobe holds rdata", bus_rdata, 32'h1);

        // R5 on a routed dsp bit: event and clear in one cycle
        drive(1'b0, 2'd0, '0, 4'b0100);
        drive(1'b1, 2'd0, 32'h4, 4'b0100);
        check("R5 dsp held", {31'd0, irq_dsp}, 32'h1);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset host", {31'd0, irq_host}, '0);
        check("R1 mid reset dsp", {31'd0, irq_dsp}, '0);
        check("R1 mid reset rdata", bus_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(2'd0, rd); check("R1 status after reset", rd, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule